// File: doc/BRIEF.md
# Emergency-Stop Supervisor Latch

This block keeps a machine-control system in emergency stop until a guarded release sequence succeeds. An external hardware watchdog can demand a stop at any moment. That demand clears the run state at once through an asynchronous path, so it works even when the clock has died. Leaving stop is fully synchronous. It needs all of the following at once:

- a software watchdog that has been kicked recently;
- every fault line clear;
- a fresh exit command strobe;
- a shared active-low stop bus seen high while that strobe is live.

Once running, any fault, a stale software watchdog or a new hardware stop request drops the block back into stop. It then stays there until a new strobe arrives.

While stopped, the block pulls the shared bus low so that other modules on it see the condition. It lets go of the bus only during a live strobe, which lets the bus rise under its pull-up unless another module is holding it down. Step and auxiliary outputs are ANDed with the run state, so none of them can toggle while the machine is stopped.

Top module: `estop_supervisor`

## Requirements
- R1: After reset, run_o is 0, bus_low_o is 1, and step_o and aux_o are all zero.
- R2: A high level on wd_stop_i drives run_o to 0 without waiting for any clock edge. No release happens while wd_stop_i is high.
- R3: Each kick_i pulse reloads the software watchdog. Without a further kick, run_o falls after the rising edge TIMEOUT+1 edges past the edge that sampled the kick. While the watchdog is expired, including from reset until the first kick, no release happens.
- R4: Any fault_i bit at 1 (1 means fault) blocks release. If a fault bit is 1 at a rising edge while running, run_o is 0 after that edge.
- R5: A release needs a strobe that began with a 0-to-1 change of release_i. A strobe held high yields at most one release, so holding it through a later fault does not restart the block.
- R6: bus_lvl_i passes through a two-flop synchronizer before the release logic uses it. Take a strobe of L cycles, numbered from 0, in which bus_lvl_i is low for the first H cycles and high afterwards, with all other conditions met. Its release sets run_o after the edge that closes cycle H+2, provided H+2 is at most L-1; otherwise no release happens.
- R7: bus_low_o is 0 while running. It is 1 while stopped, except during a live strobe window, when the block releases the bus.
- R8: step_o equals step_i and aux_o equals aux_i while run_o is 1; both are zero while run_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wd_stop_i | input | 1 | Asynchronous stop request from the hardware watchdog, active high |
| fault_i | input | NUM_FAULTS | Fault lines, 1 = fault |
| kick_i | input | 1 | Software watchdog service pulse |
| release_i | input | 1 | Exit-stop command strobe |
| bus_lvl_i | input | 1 | Sampled level of the shared active-low stop bus |
| step_i | input | NUM_STEP | Raw motion step signals |
| aux_i | input | NUM_AUX | Raw auxiliary outputs |
| run_o | output | 1 | 1 = running, 0 = emergency stop |
| step_o | output | NUM_STEP | Step signals gated by the run state |
| aux_o | output | NUM_AUX | Auxiliary outputs gated by the run state |
| bus_low_o | output | 1 | 1 = pull the shared stop bus low |

## Verification
The release path is swept over every strobe length from 1 to 6 against every number (0 to 5) of leading cycles in which another module holds the bus low. Checking run_o cycle by cycle separates strobes whose bus-high window covers the synchronizer latency from strobes that close too soon. Each fault line is tried in two ways: held across a strobe, which must block release, and pulsed while running under a held strobe, which must drop run with no automatic re-release. The software watchdog is tried unkicked from reset, and then counted edge by edge from one kick to its timeout. The asynchronous stop is raised mid-cycle and checked before the next clock edge. Every gating pattern of the step and auxiliary inputs is applied in both states.

// File: rtl/estop_pkg.sv
package estop_pkg;
  typedef enum logic {
    ST_STOP = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  localparam int unsigned DEF_TIMEOUT    = 1000;
  localparam int unsigned DEF_NUM_FAULTS = 4;
  localparam int unsigned DEF_NUM_STEP   = 4;
  localparam int unsigned DEF_NUM_AUX    = 2;
  localparam int unsigned SYNC_STAGES    = 2;
endpackage

// File: rtl/estop_sync.sv
module estop_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_n [STAGES];

  always_comb begin
    stage_n[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_n[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= {WIDTH{RST_VAL}};
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= stage_n[s];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/estop_swdog.sv
module estop_swdog #(
  parameter int unsigned TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign expired_o = (cnt_q == LIMIT);
  assign cnt_en    = kick_i | ~expired_o;

  always_comb begin
    if (kick_i) cnt_n = '0;
    else        cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LIMIT;
    else if (cnt_en) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/estop_release.sv
module estop_release (
  input  logic clk,
  input  logic rst_n,
  input  logic release_i,
  input  logic bus_hi_i,
  input  logic ok_i,
  output logic win_o,
  output logic fire_o
);
  logic rel_d_q, armed_q, armed_n;

  assign win_o   = release_i & (armed_q | ~rel_d_q);
  assign fire_o  = win_o & bus_hi_i & ok_i;
  assign armed_n = win_o & ~fire_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_d_q <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      rel_d_q <= release_i;
      armed_q <= armed_n;
    end
  end
endmodule

// File: rtl/estop_supervisor.sv
module estop_supervisor
  import estop_pkg::*;
#(
  parameter int unsigned TIMEOUT    = DEF_TIMEOUT,
  parameter int unsigned NUM_FAULTS = DEF_NUM_FAULTS,
  parameter int unsigned NUM_STEP   = DEF_NUM_STEP,
  parameter int unsigned NUM_AUX    = DEF_NUM_AUX
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wd_stop_i,
  input  logic [NUM_FAULTS-1:0] fault_i,
  input  logic                  kick_i,
  input  logic                  release_i,
  input  logic                  bus_lvl_i,
  input  logic [NUM_STEP-1:0]   step_i,
  input  logic [NUM_AUX-1:0]    aux_i,
  output logic                  run_o,
  output logic [NUM_STEP-1:0]   step_o,
  output logic [NUM_AUX-1:0]    aux_o,
  output logic                  bus_low_o
);
  logic       rst_sync_n;
  logic       stop_s, bus_s;
  logic       wd_expired;
  logic       keep_ok, win, fire;
  logic       stop_clr_n;
  run_state_e state_q, state_n;

  estop_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sync_n)
  );

  estop_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(wd_stop_i), .q_o(stop_s)
  );

  estop_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bus_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(bus_lvl_i), .q_o(bus_s)
  );

  estop_swdog #(.TIMEOUT(TIMEOUT)) u_swdog (
    .clk(clk), .rst_n(rst_sync_n), .kick_i(kick_i), .expired_o(wd_expired)
  );

  assign keep_ok = ~(|fault_i) & ~wd_expired & ~stop_s;

  estop_release u_release (
    .clk(clk), .rst_n(rst_sync_n), .release_i(release_i),
    .bus_hi_i(bus_s), .ok_i(keep_ok), .win_o(win), .fire_o(fire)
  );

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_STOP: if (fire)     state_n = ST_RUN;
      ST_RUN:  if (!keep_ok) state_n = ST_STOP;
      default:               state_n = ST_STOP;
    endcase
  end

  assign stop_clr_n = rst_sync_n & ~wd_stop_i;

  always_ff @(posedge clk or negedge stop_clr_n) begin
    if (!stop_clr_n) state_q <= ST_STOP;
    else             state_q <= state_n;
  end

  assign run_o     = (state_q == ST_RUN);
  assign bus_low_o = ~run_o & ~win;

  for (genvar i = 0; i < NUM_STEP; i++) begin : g_step_gate
    assign step_o[i] = step_i[i] & run_o;
  end
  for (genvar i = 0; i < NUM_AUX; i++) begin : g_aux_gate
    assign aux_o[i] = aux_i[i] & run_o;
  end
endmodule

// File: rtl/estop_supervisor_chk.sv
module estop_supervisor_chk #(
  parameter int unsigned TIMEOUT    = 1000,
  parameter int unsigned NUM_FAULTS = 4,
  parameter int unsigned NUM_STEP   = 4,
  parameter int unsigned NUM_AUX    = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wd_stop_i,
  input logic [NUM_FAULTS-1:0] fault_i,
  input logic                  kick_i,
  input logic                  release_i,
  input logic                  bus_lvl_i,
  input logic [NUM_STEP-1:0]   step_i,
  input logic [NUM_AUX-1:0]    aux_i,
  input logic                  run_o,
  input logic [NUM_STEP-1:0]   step_o,
  input logic [NUM_AUX-1:0]    aux_o,
  input logic                  bus_low_o
);
  AST_HW_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wd_stop_i |-> !run_o); // R2

  AST_FAULT_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && (|fault_i)) |=> !run_o); // R4

  AST_RISE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> ($past(release_i) && ($past(fault_i) == '0))); // R5

  AST_HELD_NO_RERUN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run_o) && release_i && $past(release_i)) |=> !run_o); // R5

  AST_BUS_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> !bus_low_o); // R7

  AST_BUS_LOW_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !release_i) |-> bus_low_o); // R7

  AST_GATE_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> ((step_o == '0) && (aux_o == '0))); // R8

  AST_PASS_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> ((step_o == step_i) && (aux_o == aux_i))); // R8

  logic unused_ok;
  assign unused_ok = &{1'b0, kick_i, bus_lvl_i};
endmodule

bind estop_supervisor estop_supervisor_chk #(
  .TIMEOUT(TIMEOUT), .NUM_FAULTS(NUM_FAULTS), .NUM_STEP(NUM_STEP), .NUM_AUX(NUM_AUX)
) chk_i (.*);

// File: tb/estop_supervisor_tb_top.sv
`timescale 1ns/1ps
module estop_supervisor_tb_top;
  localparam int T  = 40;
  localparam int NF = 3;
  localparam int NS = 2;
  localparam int NA = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wd_stop;
  logic [NF-1:0] fault;
  logic          kick;
  logic          rel;
  logic          other_low;
  logic [NS-1:0] step_in;
  logic [NA-1:0] aux_in;
  logic          run;
  logic [NS-1:0] step_out;
  logic [NA-1:0] aux_out;
  logic          bus_low;
  logic          bus_lvl;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;

  always #5 clk = ~clk;

  assign bus_lvl = ~(bus_low | other_low);

  estop_supervisor #(.TIMEOUT(T), .NUM_FAULTS(NF), .NUM_STEP(NS), .NUM_AUX(NA)) dut_i (
    .clk(clk), .rst_n(rst_n), .wd_stop_i(wd_stop), .fault_i(fault), .kick_i(kick),
    .release_i(rel), .bus_lvl_i(bus_lvl), .step_i(step_in), .aux_i(aux_in),
    .run_o(run), .step_o(step_out), .aux_o(aux_out), .bus_low_o(bus_low)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic strobe(input int L, input int H, input bit may_run, input string req);
    rel = 1'b1;
    for (int c = 0; c < L; c++) begin
      other_low = (c < H);
      @(negedge clk);
      chk(req, 32'(run), 32'(may_run && (c >= H + 2)));
    end
    rel = 1'b0;
    other_low = 1'b0;
    @(negedge clk);
  endtask

  task automatic to_stop();
    if (run) begin
      fault[0] = 1'b1;
      @(negedge clk);
      fault[0] = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic do_release();
    do_kick();
    strobe(4, 0, 1'b1, "R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wd_stop = 1'b0; fault = '0; kick = 1'b0; rel = 1'b0;
    other_low = 1'b0; step_in = '1; aux_in = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 run", 32'(run), 0);
    chk("R1 bus", 32'(bus_low), 1);
    chk("R1 step", 32'(step_out), 0);
    chk("R1 aux", 32'(aux_out), 0);

    // R3: watchdog expired from reset, no kick yet
    strobe(6, 0, 1'b0, "R3 unkicked");

    // R6: sweep of strobe length against bus-held-low cycles
    for (int L = 1; L <= 6; L++) begin
      for (int H = 0; H <= 5; H++) begin
        do_kick();
        strobe(L, H, 1'b1, "R6 sweep");
        to_stop();
      end
    end

    // R7: bus drive in both states
    chk("R7 stop", 32'(bus_low), 1);
    do_release();
    chk("R7 run", 32'(bus_low), 0);

    // R3: exact timeout count after one kick
    do_kick();
    for (int n = 1; n <= T + 1; n++) begin
      @(negedge clk);
      chk("R3 timeout", 32'(run), 32'(n <= T));
    end
    strobe(6, 0, 1'b0, "R3 expired");

    // R4 / R5: each fault line
    for (int i = 0; i < NF; i++) begin
      do_kick();
      fault[i] = 1'b1;
      strobe(6, 0, 1'b0, "R4 blocked");
      fault[i] = 1'b0;
      @(negedge clk);
      do_kick();
      rel = 1'b1;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        chk("R6 held", 32'(run), 32'(c >= 2));
      end
      fault[i] = 1'b1;
      @(negedge clk);
      chk("R4 drop", 32'(run), 0);
      fault[i] = 1'b0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        chk("R5 held strobe", 32'(run), 0);
      end
      rel = 1'b0;
      @(negedge clk);
    end

    // R2: asynchronous stop between clock edges
    do_release();
    #1 wd_stop = 1'b1;
    #1 chk("R2 async", 32'(run), 0);
    chk("R7 async", 32'(bus_low), 1);
    @(negedge clk);
    do_kick();
    strobe(6, 0, 1'b0, "R2 blocked");
    wd_stop = 1'b0;
    repeat (4) @(negedge clk);

    // R8: gating patterns in stop and in run
    for (int p = 0; p < (1 << (NS + NA)); p++) begin
      {step_in, aux_in} = (NS + NA)'(p);
      #1;
      chk("R8 stop", 32'({step_out, aux_out}), 0);
    end
    @(negedge clk);
    do_release();
    for (int p = 0; p < (1 << (NS + NA)); p++) begin
      {step_in, aux_in} = (NS + NA)'(p);
      #1;
      chk("R8 run", 32'({step_out, aux_out}), 32'(p));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule